// File: doc/BRIEF.md
# Two-Bank Line Hold and Polarity Sequencer

This block sequences a pair of hold registers for every column of a line-driving array. The two registers of a column take turns. During one line period one register captures the sample for that column, and the other drives the column with the value captured during the line before. Sample values are digital codes. The driven result is a code plus an enable, and the enable stands in for the high-impedance state of a real output stage.

A line-sync input marks the line boundaries. On the first clock edge that sees line sync low, the block does three things: it disables all column outputs, it swaps the roles of the two registers, and it latches the polarity input. While line sync stays low, the register that will capture next is held at a common reference code. When line sync returns high, the outputs are enabled again and show the codes captured in the previous line.

Each code is stored already signed, as the common code plus or minus the sample magnitude. The sign of a column comes from the latched polarity and from an arrangement input. With the arrangement input low, every column uses the same sign. With it high, neighbouring columns alternate sign. After each line boundary, capture strobes are locked out for a parameterised number of cycles, which models the settling of the reset. A strobe that is refused raises a one-cycle error pulse.

Top module: `line_hold_seq`

## Requirements
- R1: While `rstN` is low, `colEn` is all zeros, every `colCode` slot equals `COMMON_CODE`, and `earlyErr` is 0.
- R2: The clock edge that first samples `lineSync` low (the fall edge) clears every bit of `colEn` from the next cycle on. While `colEn` is 0, every `colCode` slot reads `COMMON_CODE`.
- R3: The clock edge that first samples `lineSync` high sets every bit of `colEn` from the next cycle on. From then, `colCode` shows the codes captured during the line that ended at the previous fall edge.
- R4: While the outputs stay enabled, `colCode` does not change, because captures go only to the other register of each column.
- R5: A column that has no accepted strobe during a line shows `COMMON_CODE` in the following line.
- R6: The polarity used for captures is the value of `polarity` at the fall edge. Later changes of `polarity`, whether line sync is low or high, have no effect on it.
- R7: With `arrange` = 0, an accepted strobe of magnitude m stores `COMMON_CODE + m` when the latched polarity is 1 and `COMMON_CODE - m` when it is 0, in every column.
- R8: With `arrange` = 1, columns with an even index (0, 2, 4, ...) follow R7. Columns with an odd index use the inverted latched polarity.
- R9: A strobe is accepted only when `lineSync` is high and the strobe is sampled at least `SETTLE_CYC + 1` edges after the fall edge (or after reset). An earlier strobe is dropped, and `earlyErr` is 1 in the cycle after it.
- R10: A strobe sampled while `lineSync` is low, including on the fall edge itself, is dropped and raises `earlyErr` in the next cycle.
- R11: Several accepted strobes to the same column within one line leave the last one's code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| lineSync | input | 1 | Line boundary input: low phase separates lines |
| polarity | input | 1 | Polarity for the next line, latched at the fall edge |
| arrange | input | 1 | 0: all columns share the sign, 1: alternating sign per column |
| sampleStrobe | input | 1 | Capture request for one column |
| sampleCol | input | $clog2(NUM_COLS) | Column index of the capture |
| sampleMag | input | MAG_W | Unsigned sample magnitude |
| colCode | output | NUM_COLS*CODE_W | Driven codes, column c in bits [c*CODE_W +: CODE_W] |
| colEn | output | NUM_COLS | Per-column drive enable (0 means high impedance) |
| earlyErr | output | 1 | One-cycle pulse for a dropped strobe |

## Verification
The sharpest collision is a capture strobe that lands on the same edge as the line-sync fall. On that edge the registers swap roles and the register that was driving begins to clear, so the strobe must be dropped and must not reach either register. The bench drives a strobe on that exact edge toward a column that nothing else writes in that line. It expects an error pulse one cycle later, and it expects the column to show the common code when the next line is displayed. A second boundary sets strobes on the last refused and the first accepted edge of the settle window.

// File: rtl/lhs_pkg.sv
package lhs_pkg;

  // Strobes from the sequencing control to the hold datapath
  typedef struct packed {
    logic capture;   // write the selected column of the capture bank
    logic capBank;   // bank that captures in this line
    logic clrEn;     // force a bank to the common code
    logic clrBank;   // bank being forced to the common code
    logic outEn;     // drive enable for all columns
    logic drvBank;   // bank that drives the columns
  } lhsStrobe_t;

endpackage

// File: rtl/lhs_ctrl.sv
module lhs_ctrl
  import lhs_pkg::*;
#(
  parameter int SETTLE_CYC = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineSync,
  input  logic       polarity,
  input  logic       sampleStrobe,
  output lhsStrobe_t strb,
  output logic       linePol,
  output logic       earlyErr
);

  localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE_CYC);

  logic             lsPrev;
  logic             capSel;
  logic             outEnQ;
  logic             polQ;
  logic             errQ;
  logic [CNT_W-1:0] settleCnt;
  logic             fallNow;
  logic             riseNow;
  logic             accept;

  assign fallNow = lsPrev & ~lineSync;
  assign riseNow = ~lsPrev & lineSync;
  assign accept  = sampleStrobe & lineSync & (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsPrev    <= 1'b0;
      capSel    <= 1'b0;
      outEnQ    <= 1'b0;
      polQ      <= 1'b0;
      errQ      <= 1'b0;
      settleCnt <= SETTLE_V;
    end else begin
      lsPrev <= lineSync;
      errQ   <= sampleStrobe & ~accept;
      if (fallNow) begin
        capSel    <= ~capSel;
        outEnQ    <= 1'b0;
        polQ      <= polarity;
        settleCnt <= SETTLE_V;
      end else begin
        if (riseNow) outEnQ <= 1'b1;
        if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.capture = accept;
    strb.capBank = capSel;
    strb.clrEn   = ~lineSync;
    // on the fall edge the old driving bank becomes the capture bank
    strb.clrBank = fallNow ? ~capSel : capSel;
    strb.outEn   = outEnQ;
    strb.drvBank = ~capSel;
  end

  assign linePol  = polQ;
  assign earlyErr = errQ;

endmodule

// File: rtl/lhs_bank_dp.sv
module lhs_bank_dp
  import lhs_pkg::*;
#(
  parameter int NUM_COLS    = 6,
  parameter int CODE_W      = 8,
  parameter int MAG_W       = 7,
  parameter int COMMON_CODE = 128
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  lhsStrobe_t                   strb,
  input  logic                         linePol,
  input  logic                         arrange,
  input  logic [$clog2(NUM_COLS)-1:0]  sampleCol,
  input  logic [MAG_W-1:0]             sampleMag,
  output logic [NUM_COLS*CODE_W-1:0]   colCode,
  output logic [NUM_COLS-1:0]          colEn
);

  localparam int COL_W = $clog2(NUM_COLS);
  localparam logic [CODE_W-1:0] COMMON_V = CODE_W'(COMMON_CODE);

  logic [CODE_W-1:0] magExt;
  assign magExt = CODE_W'(sampleMag);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam bit ODD_IDX = (c % 2) == 1;

    logic [CODE_W-1:0] bank0Q;
    logic [CODE_W-1:0] bank1Q;
    logic              posOut;
    logic              hit;
    logic [CODE_W-1:0] newCode;

    always_comb begin
      posOut  = arrange ? (linePol ^ ODD_IDX) : linePol;
      hit     = (sampleCol == COL_W'(c));
      newCode = posOut ? (COMMON_V + magExt) : (COMMON_V - magExt);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank0Q <= COMMON_V;
        bank1Q <= COMMON_V;
      end else if (strb.clrEn) begin
        if (strb.clrBank) bank1Q <= COMMON_V;
        else              bank0Q <= COMMON_V;
      end else if (strb.capture && hit) begin
        if (strb.capBank) bank1Q <= newCode;
        else              bank0Q <= newCode;
      end
    end

    assign colCode[c*CODE_W +: CODE_W] =
      strb.outEn ? (strb.drvBank ? bank1Q : bank0Q) : COMMON_V;
  end

  assign colEn = {NUM_COLS{strb.outEn}};

endmodule

// File: rtl/line_hold_seq.sv
module line_hold_seq
  import lhs_pkg::*;
#(
  parameter int NUM_COLS    = 6,
  parameter int CODE_W      = 8,
  parameter int MAG_W       = 7,
  parameter int COMMON_CODE = 128,
  parameter int SETTLE_CYC  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lineSync,
  input  logic                        polarity,
  input  logic                        arrange,
  input  logic                        sampleStrobe,
  input  logic [$clog2(NUM_COLS)-1:0] sampleCol,
  input  logic [MAG_W-1:0]            sampleMag,
  output logic [NUM_COLS*CODE_W-1:0]  colCode,
  output logic [NUM_COLS-1:0]         colEn,
  output logic                        earlyErr
);

  lhsStrobe_t strb;
  logic       linePol;

  lhs_ctrl #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .lineSync(lineSync),
    .polarity(polarity),
    .sampleStrobe(sampleStrobe),
    .strb(strb),
    .linePol(linePol),
    .earlyErr(earlyErr)
  );

  lhs_bank_dp #(
    .NUM_COLS(NUM_COLS),
    .CODE_W(CODE_W),
    .MAG_W(MAG_W),
    .COMMON_CODE(COMMON_CODE)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .linePol(linePol),
    .arrange(arrange),
    .sampleCol(sampleCol),
    .sampleMag(sampleMag),
    .colCode(colCode),
    .colEn(colEn)
  );

endmodule

// File: rtl/lhs_checker.sv
module lhs_checker #(
  parameter int NUM_COLS   = 6,
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       lineSync,
  input logic                       sampleStrobe,
  input logic [NUM_COLS*CODE_W-1:0] colCode,
  input logic [NUM_COLS-1:0]        colEn,
  input logic                       earlyErr
);

  localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  // independent count of the lockout window after each line boundary
  logic             lsSeen;
  logic [CNT_W-1:0] windowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsSeen    <= 1'b0;
      windowCnt <= CNT_W'(SETTLE_CYC);
    end else begin
      lsSeen <= lineSync;
      if (lsSeen && !lineSync)  windowCnt <= CNT_W'(SETTLE_CYC);
      else if (windowCnt != '0) windowCnt <= windowCnt - 1'b1;
    end
  end

  AST_FALL_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $fell(lineSync) |=> (colEn == '0)); // R2

  AST_RISE_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $rose(lineSync) |=> (colEn == '1)); // R3

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    colEn[0] && $past(colEn[0]) |-> $stable(colCode)); // R4

  AST_LOW_STROBE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe && !lineSync |=> earlyErr); // R10

  AST_SETTLE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe && (windowCnt != '0) |=> earlyErr); // R9

  AST_QUIET_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> !earlyErr); // R9

endmodule

bind line_hold_seq lhs_checker #(
  .NUM_COLS(NUM_COLS),
  .CODE_W(CODE_W),
  .SETTLE_CYC(SETTLE_CYC)
) i_lhs_checker (
  .clk(clk),
  .rstN(rstN),
  .lineSync(lineSync),
  .sampleStrobe(sampleStrobe),
  .colCode(colCode),
  .colEn(colEn),
  .earlyErr(earlyErr)
);

// File: tb/test_line_hold_seq.sv
module test_line_hold_seq;

  localparam int NC = 6;
  localparam int CW = 8;
  localparam int MW = 7;
  localparam int CM = 128;
  localparam int ST = 6;

  typedef struct {
    int    code;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineSync = 1'b0;
  logic polarity = 1'b0;
  logic arrange = 1'b0;
  logic sampleStrobe = 1'b0;
  logic [$clog2(NC)-1:0] sampleCol = '0;
  logic [MW-1:0] sampleMag = '0;
  logic [NC*CW-1:0] colCode;
  logic [NC-1:0] colEn;
  logic earlyErr;

  always #5 clk = ~clk;

  line_hold_seq #(
    .NUM_COLS(NC), .CODE_W(CW), .MAG_W(MW), .COMMON_CODE(CM), .SETTLE_CYC(ST)
  ) i_line_hold_seq (
    .clk(clk), .rstN(rstN), .lineSync(lineSync), .polarity(polarity),
    .arrange(arrange), .sampleStrobe(sampleStrobe), .sampleCol(sampleCol),
    .sampleMag(sampleMag), .colCode(colCode), .colEn(colEn), .earlyErr(earlyErr)
  );

  int total = 0;
  int bad = 0;
  expItem_t expQ[$];
  int capArr[NC];
  string capTag[NC];
  int kEdge = 0;
  bit lsModel = 1'b0;
  bit polModel = 1'b0;
  bit expEn = 1'b0;
  bit expErr = 1'b0;
  string errTag = "R9";
  bit showPending = 1'b0;
  bit curPol = 1'b0;
  bit curArr = 1'b0;
  event lineShown;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int codeOf(int col, int mag, bit lp, bit arr);
    bit pos = arr ? (((col % 2) == 0) ? lp : !lp) : lp;
    return pos ? (CM + mag) : (CM - mag);
  endfunction

  // driver side of the scoreboard: close a line, queue what it must show
  task automatic pushLine();
    for (int c = 0; c < NC; c++) begin
      expItem_t it;
      it.code = capArr[c];
      it.tag  = capTag[c];
      expQ.push_back(it);
      capArr[c] = CM;
      capTag[c] = "R5";
    end
    showPending = 1'b1;
  endtask

  // monitor side: compare a shown line against the queued items
  initial begin
    forever begin
      @(lineShown);
      for (int c = 0; c < NC; c++) begin
        expItem_t it;
        if (expQ.size() == 0) begin
          check(1'b0, "R3 queue empty", 0, 1);
        end else begin
          it = expQ.pop_front();
          check(colCode[c*CW +: CW] == it.code, it.tag,
                int'(colCode[c*CW +: CW]), it.code);
        end
      end
    end
  end

  task automatic step(bit ls, bit st, int col, int mag);
    bit acc;
    @(negedge clk);
    check(earlyErr == expErr, errTag, int'(earlyErr), int'(expErr));
    check(colEn == {NC{expEn}}, expEn ? "R3 enable" : "R2 enable",
          int'(colEn), expEn ? ((1 << NC) - 1) : 0);
    if (!expEn) begin
      for (int c = 0; c < NC; c++)
        check(colCode[c*CW +: CW] == CM, "R2 common while off",
              int'(colCode[c*CW +: CW]), CM);
    end else if (showPending) begin
      showPending = 1'b0;
      ->lineShown;
    end
    lineSync     = ls;
    sampleStrobe = st;
    sampleCol    = ($clog2(NC))'(col);
    sampleMag    = MW'(mag);
    polarity     = curPol;
    arrange      = curArr;
    if (lsModel && !ls) begin
      kEdge    = 0;
      polModel = curPol;
      pushLine();
      expEn = 1'b0;
    end else begin
      kEdge++;
    end
    if (!lsModel && ls) expEn = 1'b1;
    acc = st && ls && (kEdge >= ST + 1);
    if (acc) begin
      if (capTag[col] != "R5" && capTag[col] != "R9" && capTag[col] != "R10")
        capTag[col] = "R11";
      else if (curPol != polModel)
        capTag[col] = "R6";
      else
        capTag[col] = curArr ? "R8" : "R7";
      capArr[col] = codeOf(col, mag, polModel, curArr);
    end else if (st && capTag[col] == "R5") begin
      capTag[col] = ls ? "R9" : "R10";
    end
    expErr = st && !acc;
    errTag = (st && !ls) ? "R10" : "R9";
    lsModel = ls;
  endtask

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      capArr[c] = CM;
      capTag[c] = "R1";
    end
    pushLine();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(colEn == '0, "R1 enable", int'(colEn), 0);
    check(earlyErr == 1'b0, "R1 err", int'(earlyErr), 0);
    for (int c = 0; c < NC; c++)
      check(colCode[c*CW +: CW] == CM, "R1 code", int'(colCode[c*CW +: CW]), CM);
    rstN = 1'b1;

    // first line after reset shows the reset codes
    repeat (4) step(1, 0, 0, 0);

    // line A: shared sign, polarity 1; polarity toggled after the fall (R6)
    curPol = 1; curArr = 0;
    step(0, 0, 0, 0);              // fall edge k0
    curPol = 0;
    step(0, 0, 0, 0);              // k1
    step(0, 1, 2, 9);              // k2 strobe while low -> R10
    step(1, 0, 0, 0);              // k3 rise
    step(1, 1, 1, 50);             // k4 early -> R9
    step(1, 0, 0, 0);              // k5
    step(1, 1, 4, 33);             // k6 last refused edge -> R9
    step(1, 1, 0, 10);             // k7 first accepted edge
    step(1, 1, 3, 127);
    step(1, 1, 5, 20);
    curPol = 1;
    step(1, 1, 0, 11);             // overwrite column 0 -> R11
    step(1, 0, 0, 0);

    // line B: alternating sign, polarity 0, strobe on the fall edge
    curPol = 0; curArr = 1;
    step(0, 1, 1, 1);              // k0 strobe on fall -> R10
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);              // rise, shows line A
    repeat (4) step(1, 0, 0, 0);   // k3..k6
    for (int c = 0; c < NC; c++) step(1, 1, c, 3 * c + 4);
    step(1, 0, 0, 0);

    // line C: alternating sign, polarity 1, full-scale magnitudes
    curPol = 1; curArr = 1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    repeat (4) step(1, 0, 0, 0);
    for (int c = 0; c < NC; c++) step(1, 1, c, 127);
    step(1, 0, 0, 0);

    // line D: shared sign, polarity 0, one column only
    curPol = 0; curArr = 0;
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    repeat (6) step(1, 0, 0, 0);
    step(1, 1, 2, 64);
    step(1, 0, 0, 0);

    // line E: no strobes at all
    curPol = 1;
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    repeat (8) step(1, 0, 0, 0);

    // closing boundary shows line E
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    repeat (3) step(1, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule